// File: doc/BRIEF.md
# Serial Flash Page Program-and-Verify Sequencer

This block runs one full program-and-verify cycle on a serial NOR flash as a single hardware sequence. Software or a host state machine first fills a local page buffer through a simple write port, then pulses `start` with a 24-bit page address. The block then runs four kinds of frame over a mode-0 SPI link, each in its own chip-select window. It sends a write-enable byte. It sends the page program frame with the whole buffer as payload. It polls the status register until the flash reports it is no longer busy. It reads the page back and compares every returned byte with the buffer byte at the same offset.

Chip select is driven by the sequencer and not by the shift engine. It stays low from the first to the last byte of a frame, however long the frame is. Because the payload comes from a local buffer, a frame never stalls and the select line never rises partway through it. Between frames the select line stays high for a programmable number of SCLK periods. When the sequence ends, a one-cycle `done` pulse reports the result. The result is pass, a timeout if the busy bit never cleared, or the offset of the first byte that differed.

Top module: `spi_flash_pgm_verify`

## Requirements
- R1: After reset, `spi_cs_n` is 1, `spi_sclk` is 0, and `busy`, `done`, `pass` and `timeout` are all 0.
- R2: Each run begins with a frame that holds only the single byte 0x06, in its own chip-select window, ahead of the program frame.
- R3: The program frame is byte 0x02, then the address bytes high, middle and low, then buffer offsets 0 up to PAGE_BYTES-1 in order. Bytes are shifted MSB first in SPI mode 0: SCLK idles low, MOSI changes on falling edges, and MISO is sampled on rising edges.
- R4: A status frame is exactly two bytes, 0x05 then 0x00. The byte received during the second byte is the status. A new status frame follows as long as bit 0 of the status is 1.
- R5: Once bit 0 of the status reads 0, a read frame follows: 0x03, the three address bytes high first, then PAGE_BYTES bytes of 0x00 on MOSI, with every received byte captured.
- R6: `spi_cs_n` never rises while a byte is being shifted. Between frames it stays high for at least CS_GAP_SCLK SCLK periods (2*CS_GAP_SCLK*HALF_DIV clocks).
- R7: At the end of a run, `done` is high for exactly one clock and `busy` falls in that same clock. If every read byte equals the buffer byte at its offset, `pass` is 1.
- R8: If any read byte differs, `pass` is 0 and `mism_off` holds the lowest offset that differed. Later differences do not overwrite it.
- R9: If POLL_LIMIT consecutive status reads all show bit 0 set, the run ends without a read frame, with `timeout` at 1 and `pass` at 0.
- R10: A `start` pulse while `busy` is 1 is ignored. The running sequence keeps its address and produces a single `done`.
- R11: A write with `buf_we` high stores `buf_wdata` at buffer offset `buf_addr`. That byte is used at the same offset in the next program frame and compare.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to run a sequence; ignored while busy |
| page_addr | input | 24 | Flash page address, sampled with start |
| buf_we | input | 1 | Page buffer write enable |
| buf_addr | input | AW | Page buffer write offset |
| buf_wdata | input | 8 | Page buffer write data |
| spi_miso | input | 1 | Serial data from flash |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_sclk | output | 1 | Serial clock, idles low |
| spi_mosi | output | 1 | Serial data to flash |
| busy | output | 1 | A sequence is running |
| done | output | 1 | One-cycle end-of-sequence pulse |
| pass | output | 1 | Last run programmed and verified cleanly |
| timeout | output | 1 | Last run aborted on busy-poll limit |
| mism_off | output | AW | First differing offset of last run |

## Verification
The `done` pulse arrives an unknown number of cycles after `start`, because the number of status polls depends on the flash model. The bench therefore waits for `done` by sampling at each falling clock edge, and reads `pass`, `timeout` and `mism_off` in that same cycle. It then waits a further fixed interval and confirms that no second pulse appeared and that `busy` has cleared. Reset values are checked one clock after reset is released. All frame content is judged by a flash model that samples MOSI on rising SCLK edges and logs each chip-select window's opcode, length and address. The model presents MISO one falling edge before the rising edge on which the design samples it. The bench also measures the chip-select high time in clocks.

// File: rtl/spv_pkg.sv
package spv_pkg;
  localparam logic [7:0] OP_WREN = 8'h06;
  localparam logic [7:0] OP_PROG = 8'h02;
  localparam logic [7:0] OP_STAT = 8'h05;
  localparam logic [7:0] OP_READ = 8'h03;

  typedef enum logic [2:0] {
    S_IDLE, S_GAP, S_PREP, S_SEND, S_WAIT
  } seq_state_t;

  typedef enum logic [1:0] {
    F_WREN, F_PROG, F_STAT, F_READ
  } frame_t;
endpackage

// File: rtl/spv_page_buf.sv
module spv_page_buf #(
  parameter int DEPTH = 256,
  parameter int DW    = 8
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic [$clog2(DEPTH)-1:0] waddr,
  input  logic [DW-1:0]            wdata,
  input  logic [$clog2(DEPTH)-1:0] raddr,
  output logic [DW-1:0]            rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/spv_byte_engine.sv
module spv_byte_engine #(
  parameter int HALF_DIV = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       go,
  input  logic [7:0] tx,
  input  logic       miso,
  output logic       sclk,
  output logic       mosi,
  output logic       active,
  output logic       done,
  output logic [7:0] rx
);
  localparam int DIVW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [DIVW-1:0] DIV_END = DIVW'(HALF_DIV - 1);

  logic [DIVW-1:0] div;
  logic [2:0]      bitn;
  logic [7:0]      tsh;
  logic [7:0]      rsh;

  always_ff @(posedge clk) begin
    if (rst) begin
      div    <= '0;
      bitn   <= '0;
      tsh    <= '0;
      rsh    <= '0;
      sclk   <= 1'b0;
      active <= 1'b0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!active) begin
        if (go) begin
          active <= 1'b1;
          tsh    <= tx;
          div    <= '0;
          bitn   <= '0;
          sclk   <= 1'b0;
        end
      end else if (div == DIV_END) begin
        div <= '0;
        if (!sclk) begin
          sclk <= 1'b1;
          rsh  <= {rsh[6:0], miso};
        end else begin
          sclk <= 1'b0;
          if (bitn == 3'd7) begin
            active <= 1'b0;
            done   <= 1'b1;
          end else begin
            bitn <= bitn + 3'd1;
            tsh  <= {tsh[6:0], 1'b0};
          end
        end
      end else begin
        div <= div + DIVW'(1);
      end
    end
  end

  assign mosi = tsh[7];
  assign rx   = rsh;

  // R3
  sclk_only_active_chk: assert property (@(posedge clk) disable iff (rst)
    sclk |-> active);

  // R3
  done_sclk_low_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (!sclk && !active));
endmodule

// File: rtl/spv_sequencer.sv
module spv_sequencer
  import spv_pkg::*;
#(
  parameter int PAGE_BYTES  = 256,
  parameter int HALF_DIV    = 2,
  parameter int POLL_LIMIT  = 1024,
  parameter int CS_GAP_SCLK = 2
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          start,
  input  logic [23:0]                   page_addr,
  input  logic                          eng_active,
  input  logic                          eng_done,
  input  logic [7:0]                    eng_rx,
  input  logic [7:0]                    buf_rdata,
  output logic [$clog2(PAGE_BYTES)-1:0] buf_raddr,
  output logic                          eng_go,
  output logic [7:0]                    eng_tx,
  output logic                          cs_n,
  output logic                          busy,
  output logic                          done,
  output logic                          pass,
  output logic                          timeout,
  output logic [$clog2(PAGE_BYTES)-1:0] mism_off
);
  localparam int AW       = $clog2(PAGE_BYTES);
  localparam int IW       = $clog2(PAGE_BYTES + 4);
  localparam int GAP_CLKS = 2 * CS_GAP_SCLK * HALF_DIV;
  localparam int GW       = $clog2(GAP_CLKS + 1);
  localparam int PW       = (POLL_LIMIT > 1) ? $clog2(POLL_LIMIT) : 1;
  localparam logic [IW-1:0] LAST_BULK = IW'(PAGE_BYTES + 3);
  localparam logic [IW-1:0] HDR_LEN   = IW'(4);

  seq_state_t     state;
  frame_t         frame;
  logic [IW-1:0]  idx;
  logic [GW-1:0]  gcnt;
  logic [PW-1:0]  pcnt;
  logic [23:0]    addr_q;
  logic           miss_seen;

  logic [7:0]     byte_now;
  logic [IW-1:0]  last_idx;
  logic           mism_now;
  logic [IW-1:0]  data_off;

  assign data_off  = idx - HDR_LEN;
  assign buf_raddr = data_off[AW-1:0];

  always_comb begin
    unique case (frame)
      F_WREN:  last_idx = '0;
      F_STAT:  last_idx = IW'(1);
      default: last_idx = LAST_BULK;
    endcase
  end

  always_comb begin
    byte_now = 8'h00;
    if (idx == '0) begin
      unique case (frame)
        F_WREN: byte_now = OP_WREN;
        F_PROG: byte_now = OP_PROG;
        F_STAT: byte_now = OP_STAT;
        F_READ: byte_now = OP_READ;
      endcase
    end else if (frame == F_PROG || frame == F_READ) begin
      if (idx == IW'(1))      byte_now = addr_q[23:16];
      else if (idx == IW'(2)) byte_now = addr_q[15:8];
      else if (idx == IW'(3)) byte_now = addr_q[7:0];
      else if (frame == F_PROG) byte_now = buf_rdata;
    end
  end

  assign mism_now = (frame == F_READ) && (idx >= HDR_LEN) && (eng_rx != buf_rdata);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      frame     <= F_WREN;
      idx       <= '0;
      gcnt      <= '0;
      pcnt      <= '0;
      addr_q    <= '0;
      miss_seen <= 1'b0;
      eng_go    <= 1'b0;
      eng_tx    <= '0;
      cs_n      <= 1'b1;
      busy      <= 1'b0;
      done      <= 1'b0;
      pass      <= 1'b0;
      timeout   <= 1'b0;
      mism_off  <= '0;
    end else begin
      eng_go <= 1'b0;
      done   <= 1'b0;
      unique case (state)
        S_IDLE: begin
          if (start) begin
            addr_q    <= page_addr;
            frame     <= F_WREN;
            gcnt      <= '0;
            miss_seen <= 1'b0;
            pass      <= 1'b0;
            timeout   <= 1'b0;
            mism_off  <= '0;
            busy      <= 1'b1;
            state     <= S_GAP;
          end
        end
        S_GAP: begin
          if (gcnt == GW'(GAP_CLKS - 1)) begin
            cs_n  <= 1'b0;
            idx   <= '0;
            state <= S_PREP;
          end else begin
            gcnt <= gcnt + GW'(1);
          end
        end
        S_PREP: state <= S_SEND;
        S_SEND: begin
          eng_go <= 1'b1;
          eng_tx <= byte_now;
          state  <= S_WAIT;
        end
        S_WAIT: begin
          if (eng_done) begin
            if (mism_now && !miss_seen) begin
              miss_seen <= 1'b1;
              mism_off  <= data_off[AW-1:0];
            end
            if (idx == last_idx) begin
              cs_n  <= 1'b1;
              gcnt  <= '0;
              state <= S_GAP;
              unique case (frame)
                F_WREN: frame <= F_PROG;
                F_PROG: begin
                  frame <= F_STAT;
                  pcnt  <= '0;
                end
                F_STAT: begin
                  if (eng_rx[0]) begin
                    if (pcnt == PW'(POLL_LIMIT - 1)) begin
                      timeout <= 1'b1;
                      done    <= 1'b1;
                      busy    <= 1'b0;
                      state   <= S_IDLE;
                    end else begin
                      pcnt <= pcnt + PW'(1);
                    end
                  end else begin
                    frame <= F_READ;
                  end
                end
                F_READ: begin
                  pass  <= !(miss_seen || mism_now);
                  done  <= 1'b1;
                  busy  <= 1'b0;
                  state <= S_IDLE;
                end
              endcase
            end else begin
              idx   <= idx + IW'(1);
              state <= S_PREP;
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // Checker-only count of consecutive clocks with select high.
  logic [GW-1:0] hi_run;
  always_ff @(posedge clk) begin
    if (rst) hi_run <= '0;
    else if (!cs_n) hi_run <= '0;
    else if (hi_run != GW'(GAP_CLKS)) hi_run <= hi_run + GW'(1);
  end

  // R6
  cs_hold_in_byte_chk: assert property (@(posedge clk) disable iff (rst)
    eng_active |-> !cs_n);

  // R6
  cs_gap_len_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(cs_n) |-> (hi_run == GW'(GAP_CLKS)));

  // R7
  done_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R7
  done_ends_busy_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  // R9
  timeout_no_pass_chk: assert property (@(posedge clk) disable iff (rst)
    timeout |-> !pass);

  // R10
  addr_hold_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> $stable(addr_q));
endmodule

// File: rtl/spi_flash_pgm_verify.sv
module spi_flash_pgm_verify #(
  parameter int PAGE_BYTES  = 256,
  parameter int HALF_DIV    = 2,
  parameter int POLL_LIMIT  = 1024,
  parameter int CS_GAP_SCLK = 2,
  localparam int AW         = $clog2(PAGE_BYTES)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [23:0]   page_addr,
  input  logic          buf_we,
  input  logic [AW-1:0] buf_addr,
  input  logic [7:0]    buf_wdata,
  input  logic          spi_miso,
  output logic          spi_cs_n,
  output logic          spi_sclk,
  output logic          spi_mosi,
  output logic          busy,
  output logic          done,
  output logic          pass,
  output logic          timeout,
  output logic [AW-1:0] mism_off
);
  logic [AW-1:0] rd_addr;
  logic [7:0]    rd_data;
  logic          eng_go;
  logic [7:0]    eng_tx;
  logic          eng_active;
  logic          eng_done;
  logic [7:0]    eng_rx;

  spv_page_buf #(.DEPTH(PAGE_BYTES), .DW(8)) u_buf (
    .clk   (clk),
    .we    (buf_we),
    .waddr (buf_addr),
    .wdata (buf_wdata),
    .raddr (rd_addr),
    .rdata (rd_data)
  );

  spv_byte_engine #(.HALF_DIV(HALF_DIV)) u_eng (
    .clk    (clk),
    .rst    (rst),
    .go     (eng_go),
    .tx     (eng_tx),
    .miso   (spi_miso),
    .sclk   (spi_sclk),
    .mosi   (spi_mosi),
    .active (eng_active),
    .done   (eng_done),
    .rx     (eng_rx)
  );

  spv_sequencer #(
    .PAGE_BYTES  (PAGE_BYTES),
    .HALF_DIV    (HALF_DIV),
    .POLL_LIMIT  (POLL_LIMIT),
    .CS_GAP_SCLK (CS_GAP_SCLK)
  ) u_seq (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .page_addr  (page_addr),
    .eng_active (eng_active),
    .eng_done   (eng_done),
    .eng_rx     (eng_rx),
    .buf_rdata  (rd_data),
    .buf_raddr  (rd_addr),
    .eng_go     (eng_go),
    .eng_tx     (eng_tx),
    .cs_n       (spi_cs_n),
    .busy       (busy),
    .done       (done),
    .pass       (pass),
    .timeout    (timeout),
    .mism_off   (mism_off)
  );

  // R3
  sclk_idle_when_deselected_chk: assert property (@(posedge clk) disable iff (rst)
    spi_cs_n |-> !spi_sclk);
endmodule

// File: tb/spi_flash_pgm_verify_bench.sv
module spi_flash_pgm_verify_bench;
  localparam int PB    = 256;
  localparam int HD    = 2;
  localparam int PL    = 8;
  localparam int GAPS  = 2;
  localparam int MINGAP = 2 * GAPS * HD;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [23:0] page_addr = '0;
  logic buf_we = 1'b0;
  logic [7:0] buf_addr = '0;
  logic [7:0] buf_wdata = '0;
  logic spi_miso = 1'b0;
  logic spi_cs_n, spi_sclk, spi_mosi, busy, done, pass, timeout;
  logic [7:0] mism_off;

  always #2 clk = ~clk;

  spi_flash_pgm_verify #(.PAGE_BYTES(PB), .HALF_DIV(HD), .POLL_LIMIT(PL),
                         .CS_GAP_SCLK(GAPS)) u_spi_flash_pgm_verify (
    .clk(clk), .rst(rst), .start(start), .page_addr(page_addr),
    .buf_we(buf_we), .buf_addr(buf_addr), .buf_wdata(buf_wdata),
    .spi_miso(spi_miso), .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk),
    .spi_mosi(spi_mosi), .busy(busy), .done(done), .pass(pass),
    .timeout(timeout), .mism_off(mism_off)
  );

  int checks = 0;
  int errors = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // ---------------- flash model ----------------
  logic [7:0] img     [PB];
  logic [7:0] ref_buf [PB];
  logic [7:0] fop     [64];
  int         flen    [64];
  logic [23:0] faddr  [64];
  int nfr, prog_bad, mosi_bad, busy_left, busy_cfg, cor_a, cor_b;
  bit in_frame, load;
  logic [7:0] sh_in, out_sh, nxt, cur_op;
  int bitc, bytec;
  logic [23:0] a_acc;

  always @(negedge spi_cs_n) begin
    in_frame = 1; bitc = 0; bytec = 0; load = 0; out_sh = 0; spi_miso = 0;
  end

  always @(posedge spi_cs_n) begin
    if (in_frame) begin
      in_frame = 0;
      if (nfr < 64) flen[nfr] = bytec;
      if (cur_op == 8'h02 && bytec == PB + 4) busy_left = busy_cfg;
      nfr++;
    end
  end

  task automatic take_byte(input logic [7:0] b);
    int off;
    if (bytec == 0) begin
      cur_op = b;
      if (nfr < 64) fop[nfr] = b;
    end else if ((cur_op == 8'h02 || cur_op == 8'h03) && bytec <= 3) begin
      a_acc = {a_acc[15:0], b};
      if (bytec == 3 && nfr < 64) faddr[nfr] = a_acc;
    end else if (cur_op == 8'h02 && bytec < PB + 4) begin
      img[bytec-4] = b;
      if (b != ref_buf[bytec-4]) prog_bad++;
    end else if (cur_op == 8'h03 || cur_op == 8'h05) begin
      if (b != 8'h00) mosi_bad++;
    end
    if (cur_op == 8'h05 && bytec == 1 && busy_left > 0) busy_left--;
    nxt = 8'h00;
    if (cur_op == 8'h05) nxt = {7'b0, busy_left > 0};
    off = bytec + 1 - 4;
    if (cur_op == 8'h03 && off >= 0 && off < PB) begin
      nxt = img[off];
      if (off == cor_a) nxt = nxt ^ 8'h5A;
      if (off == cor_b) nxt = nxt ^ 8'h81;
    end
    load = 1;
  endtask

  always @(posedge spi_sclk) begin
    if (!spi_cs_n) begin
      sh_in = {sh_in[6:0], spi_mosi};
      bitc++;
      if (bitc == 8) begin
        bitc = 0;
        take_byte(sh_in);
        bytec++;
      end
    end
  end

  always @(negedge spi_sclk) begin
    if (!spi_cs_n) begin
      if (load) begin out_sh = nxt; load = 0; end
      else out_sh = {out_sh[6:0], 1'b0};
      spi_miso = out_sh[7];
    end
  end

  // select-high width and done-pulse monitors
  int hi_cnt = 0;
  int min_gap = 1000000;
  int done_cnt = 0;
  always @(posedge clk) begin
    if (done) done_cnt++;
    if (spi_cs_n) hi_cnt++;
    else begin
      if (hi_cnt > 0 && hi_cnt < min_gap) min_gap = hi_cnt;
      hi_cnt = 0;
    end
  end

  // ---------------- tasks ----------------
  task automatic load_buf(input int mulv, input int addv);
    for (int i = 0; i < PB; i++) begin
      @(negedge clk);
      buf_we = 1; buf_addr = 8'(i); buf_wdata = 8'(i * mulv + addv);
      ref_buf[i] = 8'(i * mulv + addv);
    end
    @(negedge clk);
    buf_we = 0;
  endtask

  logic got_pass, got_to;
  int got_off;

  task automatic run(input logic [23:0] a, input int bcfg, input int ca,
                     input int cb, input bit mid_start);
    int n;
    nfr = 0; prog_bad = 0; mosi_bad = 0; busy_cfg = bcfg; busy_left = 0;
    cor_a = ca; cor_b = cb; min_gap = 1000000; done_cnt = 0; cur_op = 0;
    @(negedge clk);
    page_addr = a; start = 1;
    @(negedge clk);
    start = 0;
    if (mid_start) begin
      repeat (3000) @(negedge clk);
      page_addr = 24'hABCDEF; start = 1;
      @(negedge clk);
      start = 0;
    end
    n = 0;
    while (!done && n < 60000) begin @(negedge clk); n++; end
    chk(done == 1'b1, "R7", "done seen", int'(done), 1);
    chk(busy == 1'b0, "R7", "busy low with done", int'(busy), 0);
    got_pass = pass; got_to = timeout; got_off = int'(mism_off);
    repeat (40) @(negedge clk);
    chk(done_cnt == 1, "R7", "done pulse count", done_cnt, 1);
  endtask

  task automatic check_frames(input logic [23:0] a, input int polls);
    chk(nfr == polls + 3, "R4", "frame count", nfr, polls + 3);
    chk(fop[0] == 8'h06 && flen[0] == 1, "R2", "write-enable frame", int'(fop[0]), 6);
    chk(fop[1] == 8'h02 && flen[1] == PB + 4, "R3", "program frame length", flen[1], PB + 4);
    chk(faddr[1] == a, "R3", "program address", int'(faddr[1]), int'(a));
    chk(prog_bad == 0, "R3", "program payload mismatches", prog_bad, 0);
    for (int k = 0; k < polls; k++)
      chk(fop[2+k] == 8'h05 && flen[2+k] == 2, "R4", "status frame", flen[2+k], 2);
    chk(fop[polls+2] == 8'h03 && flen[polls+2] == PB + 4, "R5", "read frame",
        int'(fop[polls+2]), 3);
    chk(faddr[polls+2] == a, "R5", "read address", int'(faddr[polls+2]), int'(a));
    chk(mosi_bad == 0, "R5", "nonzero MOSI on dummy bytes", mosi_bad, 0);
    chk(min_gap >= MINGAP, "R6", "select high clocks", min_gap, MINGAP);
  endtask

  task automatic t_reset;
    chk(spi_cs_n == 1'b1, "R1", "cs_n", int'(spi_cs_n), 1);
    chk(spi_sclk == 1'b0, "R1", "sclk", int'(spi_sclk), 0);
    chk({busy, done, pass, timeout} == 4'b0, "R1", "status flags",
        int'({busy, done, pass, timeout}), 0);
  endtask

  task automatic t_clean_with_restart;
    load_buf(7, 3);
    run(24'h123400, 3, -1, -1, 1'b1);
    check_frames(24'h123400, 4);
    chk(got_pass == 1'b1, "R7", "pass", int'(got_pass), 1);
    chk(got_to == 1'b0, "R7", "timeout", int'(got_to), 0);
    chk(faddr[6] != 24'hABCDEF, "R10", "address kept during run", int'(faddr[6]), 24'h123400);
  endtask

  task automatic t_two_mismatches;
    load_buf(13, 200);
    // R11: rewrite one byte; next program frame and compare use it
    @(negedge clk); buf_we = 1; buf_addr = 8'd77; buf_wdata = 8'hC3; ref_buf[77] = 8'hC3;
    @(negedge clk); buf_we = 0;
    run(24'h00FF00, 0, 5, 200, 1'b0);
    check_frames(24'h00FF00, 1);
    chk(img[77] == 8'hC3, "R11", "rewritten byte programmed", int'(img[77]), 195);
    chk(got_pass == 1'b0, "R8", "pass", int'(got_pass), 0);
    chk(got_off == 5, "R8", "first mismatch offset", got_off, 5);
  endtask

  task automatic t_last_byte_mismatch;
    load_buf(1, 0);
    run(24'hFFFF00, 1, PB - 1, -1, 1'b0);
    check_frames(24'hFFFF00, 2);
    chk(got_pass == 1'b0, "R8", "pass at last offset", int'(got_pass), 0);
    chk(got_off == PB - 1, "R8", "last offset", got_off, PB - 1);
  endtask

  task automatic t_timeout;
    load_buf(3, 1);
    run(24'h040000, 100, -1, -1, 1'b0);
    chk(nfr == PL + 2, "R9", "frames before abort", nfr, PL + 2);
    chk(fop[PL+1] == 8'h05, "R9", "last frame is status", int'(fop[PL+1]), 5);
    chk(got_to == 1'b1, "R9", "timeout", int'(got_to), 1);
    chk(got_pass == 1'b0, "R9", "pass", int'(got_pass), 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_clean_with_restart();
    t_two_mismatches();
    t_last_byte_mismatch();
    t_timeout();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule